// File: doc/BRIEF.md
# Hash message intake front-end

This block sits between a simple register-write port and a downstream hash engine. A host pushes 32-bit message words by writing to any word-aligned address inside a window. Each word can be byte-reversed on entry so that the engine always sees big-endian data. The word is then queued in a small FIFO. The FIFO offers its head to the engine through a valid/ready handshake, but only while the engine-enable configuration bit is set. While that bit is clear, queued words stay where they are.

Beside the data path, the block keeps a 64-bit count of accepted message bits. It exposes a status word with the FIFO empty flag, the full flag and the entry count. It raises a one-cycle interrupt pulse when the FIFO fills. A write that arrives while the FIFO is full is dropped without effect. It also decodes a command register into one-cycle start and process strobes. The start strobe clears the length count.

The block has no state machine. Its only sequential state is the configuration register, the FIFO pointers and count, the length counter and a one-bit delayed copy of the full flag.

Top module: `hash_msg_intake`

## Requirements
- R1: After reset the FIFO is empty and the length is 0. CFG reads 0x002: bit 0 is engine enable, reset 0, and bit 1 is byte swap, reset 1. STATUS reads 0x001.
- R2: A write with `wr_en` high is a push when the address is word aligned (bits 1:0 zero) and lies in 0x800 through 0xFFF. A write to an unaligned address or to an address outside that window pushes nothing.
- R3: When CFG bit 1 is 1, a pushed word w is stored as {w[7:0], w[15:8], w[23:16], w[31:24]}. When the bit is 0, the word is stored unchanged.
- R4: A push that arrives while the FIFO holds 16 words, with no pop in the same cycle, changes neither the FIFO contents nor the length.
- R5: STATUS (offset 0x008) has bit 0 = empty, bit 1 = full and bits 8:4 = entry count (0 to 16). All other bits read 0.
- R6: The length increases by 32 for each accepted push. It is readable as the low half at 0x00C and the high half at 0x010. Its three low bits are always 0.
- R7: A write to CMD (offset 0x004) with bit 0 set drives `start_stb` high during that write cycle and clears the length at the end of the cycle. Bit 1 drives `proc_stb` in the same way. Reads of CMD return 0.
- R8: `full_irq` is high for exactly the first cycle in which the FIFO is full.
- R9: `eng_valid` is high only when CFG bit 0 is 1 and the FIFO is non-empty. A word leaves only in a cycle with `eng_valid` and `eng_ready` both high, and words leave in push order.
- R10: A push and a pop in the same cycle on a full FIFO are both accepted. The count stays at 16 and the length grows by 32.
- R11: A write to CFG (offset 0x000) updates both bits. A read of CFG returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 13 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 13 | Read byte address (combinational read) |
| rd_data | output | 32 | Read data for `rd_addr` |
| eng_valid | output | 1 | FIFO head is offered to the engine |
| eng_data | output | 32 | FIFO head word |
| eng_ready | input | 1 | Engine accepts the head word |
| start_stb | output | 1 | One-cycle start command strobe |
| proc_stb | output | 1 | One-cycle process command strobe |
| full_irq | output | 1 | One-cycle pulse when the FIFO becomes full |

## Verification
Pushes are made at the window's lowest address, its highest address and a middle address. These are mixed with an unaligned write and with writes just below and just above the window, which separates a correct window decode from an off-by-one edge. The same traffic is run with the swap bit set and then clear, so a swap applied in the wrong case or in the wrong byte order shows up on `eng_data`. The FIFO is filled to capacity, pushed once more with no pop, and then pushed together with a pop. The first case must leave everything unchanged. The second must keep the count at 16 while the length still grows. A cycle-level reference model checks every output, and every read of the address under test, on each clock.

// File: rtl/msgin_pkg.sv
package msgin_pkg;
    localparam int DATA_W   = 32;
    localparam int OFS_CFG  = 'h000;
    localparam int OFS_CMD  = 'h004;
    localparam int OFS_STAT = 'h008;
    localparam int OFS_LENL = 'h00C;
    localparam int OFS_LENH = 'h010;
    localparam int WIN_LO   = 'h800;
    localparam int WIN_HI   = 'hFFF;

    typedef struct packed {
        logic swap;
        logic eng_en;
    } cfg_t;

    function automatic logic [DATA_W-1:0] byte_rev(input logic [DATA_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/msgin_decode.sv
module msgin_decode
    import msgin_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg,
    output logic              push_req,
    output logic [DATA_W-1:0] push_word,
    output logic              start_stb,
    output logic              proc_stb
);
    logic aligned, in_win, cfg_hit, cmd_hit;

    always_comb begin
        aligned   = (wr_addr[1:0] == 2'b00);
        in_win    = (wr_addr >= AW'(WIN_LO)) && (wr_addr <= AW'(WIN_HI));
        cfg_hit   = wr_en && (wr_addr == AW'(OFS_CFG));
        cmd_hit   = wr_en && (wr_addr == AW'(OFS_CMD));
        push_req  = wr_en && aligned && in_win;
        push_word = cfg.swap ? byte_rev(wr_data) : wr_data;
        start_stb = cmd_hit && wr_data[0];
        proc_stb  = cmd_hit && wr_data[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.eng_en <= 1'b0;
            cfg.swap   <= 1'b1;
        end else if (cfg_hit) begin
            cfg.eng_en <= wr_data[0];
            cfg.swap   <= wr_data[1];
        end
    end

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |-> !push_req);
endmodule

// File: rtl/msgin_fifo.sv
module msgin_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          push_ok
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          pop_ok;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
        pop_ok  = pop && !empty;
        push_ok = push_req && (!full || pop_ok);
        head    = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (pop_ok)  rd_ptr <= nxt(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop) |=> (count == CW'(DEPTH)));
    // R10
    full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && pop) |=> (count == CW'(DEPTH)));
    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push_req) |=> empty);
endmodule

// File: rtl/msgin_lenctr.sv
module msgin_lenctr #(
    parameter int LEN_W = 64,
    parameter int STEP  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [LEN_W-1:0] len
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      len <= '0;
        else if (clear)  len <= '0;
        else if (inc)    len <= len + LEN_W'(STEP);
    end

    // R6
    byte_gran_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len[2:0] == 3'b000);
    // R7
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (len == '0));
    // R6
    step_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clear) |=> (len == $past(len) + LEN_W'(STEP)));
endmodule

// File: rtl/hash_msg_intake.sv
module hash_msg_intake
    import msgin_pkg::*;
#(
    parameter int AW    = 13,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int LW   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              eng_valid,
    output logic [DATA_W-1:0] eng_data,
    input  logic              eng_ready,
    output logic              start_stb,
    output logic              proc_stb,
    output logic              full_irq
);
    cfg_t              cfg;
    logic              push_req, push_ok, f_empty, f_full, was_full, pop;
    logic [DATA_W-1:0] push_word;
    logic [CW-1:0]     f_count;
    logic [LW-1:0]     len;

    msgin_decode #(.AW(AW)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg(cfg), .push_req(push_req),
        .push_word(push_word), .start_stb(start_stb), .proc_stb(proc_stb)
    );

    msgin_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_word),
        .pop(pop), .head(eng_data), .count(f_count), .empty(f_empty),
        .full(f_full), .push_ok(push_ok)
    );

    msgin_lenctr #(.LEN_W(LW), .STEP(DATA_W)) u_len (
        .clk(clk), .rst_n(rst_n), .clear(start_stb), .inc(push_ok), .len(len)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) was_full <= 1'b0;
        else        was_full <= f_full;
    end

    always_comb begin
        eng_valid = cfg.eng_en && !f_empty;
        pop       = eng_valid && eng_ready;
        full_irq  = f_full && !was_full;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            AW'(OFS_CFG):  rd_data[1:0] = {cfg.swap, cfg.eng_en};
            AW'(OFS_STAT): begin
                rd_data[0]      = f_empty;
                rd_data[1]      = f_full;
                rd_data[4 +: CW] = f_count;
            end
            AW'(OFS_LENL): rd_data = len[31:0];
            AW'(OFS_LENH): rd_data = len[63:32];
            default:       rd_data = '0;
        endcase
    end

    // R8
    irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_irq |=> !full_irq);
    // R9
    gated_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid |-> (cfg.eng_en && f_count != '0));
endmodule

// File: tb/sim_hash_msg_intake.sv
module sim_hash_msg_intake;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [12:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        eng_valid, start_stb, proc_stb, full_irq;
    logic [31:0] eng_data;
    logic        eng_ready = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hash_msg_intake u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .eng_valid(eng_valid), .eng_data(eng_data), .eng_ready(eng_ready),
        .start_stb(start_stb), .proc_stb(proc_stb), .full_irq(full_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [31:0] q[$];
    logic [63:0] m_len;
    bit m_en, m_swap, m_wasfull;

    function automatic logic [31:0] exp_rd(input logic [12:0] a);
        case (a)
            13'h000: return {30'd0, m_swap, m_en};
            13'h008: return {23'd0, 5'(q.size()), 2'd0, q.size() == 16, q.size() == 0};
            13'h00C: return m_len[31:0];
            13'h010: return m_len[63:32];
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_len = 0; m_en = 0; m_swap = 1; m_wasfull = 0;
        end else begin
            bit pop, push;
            logic [31:0] w;
            pop  = m_en && q.size() > 0 && eng_ready;
            push = wr_en && wr_addr[1:0] == 0 && wr_addr >= 13'h800 &&
                   wr_addr <= 13'hFFF && (q.size() < 16 || pop);
            w = m_swap ? {wr_data[7:0], wr_data[15:8], wr_data[23:16], wr_data[31:24]} : wr_data;
            m_wasfull = (q.size() == 16);
            if (pop) void'(q.pop_front());
            if (push) begin q.push_back(w); m_len += 32; end
            if (wr_en && wr_addr == 13'h004 && wr_data[0]) m_len = 0;
            if (wr_en && wr_addr == 13'h000) begin m_en = wr_data[0]; m_swap = wr_data[1]; end
        end
        #5;
        if (rst_n) begin
            chk("R9 eng_valid", 64'(eng_valid), 64'(m_en && q.size() > 0));
            if (q.size() > 0) chk("R3/R9 eng_data", 64'(eng_data), 64'(q[0]));
            chk("R8 full_irq", 64'(full_irq), 64'(q.size() == 16 && !m_wasfull));
            chk("R7 start_stb", 64'(start_stb), 64'(wr_en && wr_addr == 13'h004 && wr_data[0]));
            chk("R7 proc_stb", 64'(proc_stb), 64'(wr_en && wr_addr == 13'h004 && wr_data[1]));
            chk("R5/R6/R11 rd_data", 64'(rd_data), 64'(exp_rd(rd_addr)));
        end
    end

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic rd_chk(input logic [12:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        wr_en = 1'b0; rd_addr = a;
        @(posedge clk); #5;
        chk(tag, 64'(rd_data), 64'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(13'h000, 32'h002, "R1 cfg");
        rd_chk(13'h008, 32'h001, "R1 status");
        rd_chk(13'h00C, 32'h000, "R1 length");
        // R2 window edges, unaligned and outside writes, swap on (R3)
        wr(13'h800, 32'h11223344);
        wr(13'hFFC, 32'hA1B2C3D4);
        wr(13'hA40, 32'h0F0E0D0C);
        wr(13'h7FC, 32'h55555555);
        wr(13'h802, 32'h66666666);
        wr(13'h1000, 32'h77777777);
        rd_chk(13'h008, 32'h030, "R2 status");
        rd_chk(13'h00C, 32'd96, "R6 length");
        // R11 swap off
        wr(13'h000, 32'h0);
        rd_chk(13'h000, 32'h0, "R11 cfg");
        for (int i = 0; i < 13; i++) wr(13'h800 + 13'(4 * i), 32'hC0DE0000 + 32'(i));
        rd_chk(13'h008, 32'h102, "R5 status full");
        rd_chk(13'h00C, 32'd512, "R6 length full");
        // R4 push while full is discarded
        wr(13'h900, 32'hDEADBEEF);
        rd_chk(13'h008, 32'h102, "R4 status");
        rd_chk(13'h00C, 32'd512, "R4 length");
        // enable engine with ready low: data held
        wr(13'h000, 32'h1);
        rd_chk(13'h008, 32'h102, "R9 held");
        // R10 push and pop together on full
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 13'h804; wr_data = 32'hFEEDF00D; eng_ready = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; eng_ready = 1'b0; rd_addr = 13'h008;
        @(posedge clk); #5;
        chk("R10 status", 64'(rd_data), 64'h102);
        rd_chk(13'h00C, 32'd544, "R10 length");
        // R7 start clears length, process strobe, CMD reads 0
        wr(13'h004, 32'h1);
        rd_chk(13'h00C, 32'd0, "R7 length cleared");
        wr(13'h004, 32'h2);
        rd_chk(13'h004, 32'd0, "R7 cmd read");
        // drain with swap on and pushes interleaved
        wr(13'h000, 32'h3);
        @(negedge clk); wr_en = 1'b0; eng_ready = 1'b1;
        wr(13'hFF8, 32'h01020304);
        wr(13'h820, 32'hAABBCCDD);
        @(negedge clk); wr_en = 1'b0;
        repeat (24) @(negedge clk);
        rd_chk(13'h008, 32'h001, "R9 drained");
        rd_chk(13'h00C, 32'd64, "R6 after start");
        rd_chk(13'h010, 32'd0, "R6 upper half");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule